// File: doc/BRIEF.md
# Write-Strobe Qualifier for an Asynchronous Parallel Memory Port

This block sits behind the pins of an asynchronous, NOR-style memory bus and turns the active-low chip-enable, write-enable and output-enable strobes into clean write events for an on-chip command decoder. A system clock much faster than the bus oversamples the three strobes. Each strobe goes through a two-flop synchroniser and a stability filter, so a short noise pulse never reaches the write logic.

A write window is open only while chip-enable and write-enable are both low and output-enable is high. The address on the bus is taken when the window opens, which is the later of the two enable falls. The data is taken when the window closes, which is the earlier of the two enable rises. A completed window produces a one-cycle `wr_valid` pulse that carries the address and data captured for it. A low-supply lockout input blocks writes and raises a reset request toward the command logic. A power-up input holds writes off until the supply sequence is done and both enables have been seen released.

Top module: `wr_cycle_qualifier`

## Requirements
- R1: While reset is held and right after it, `wr_valid`, `cmd_reset`, `wr_addr` and `wr_data` are all zero.
- R2: A low pulse on `ce_n`, `we_n` or `oe_n` that is shorter than GLITCH_CYCLES clock cycles has no effect. A low pulse of exactly GLITCH_CYCLES cycles is acted on.
- R3: A write window is open only while `ce_n` and `we_n` are both low and `oe_n` is high. Each window that closes normally gives exactly one `wr_valid` pulse.
- R4: `wr_addr` carries the bus address seen when the window opens, that is, when the later of `ce_n` and `we_n` falls.
- R5: `wr_data` carries the bus data seen when the window closes, that is, when the earlier of `ce_n` and `we_n` rises.
- R6: If `oe_n` is low when both enables fall, no write happens. If `oe_n` falls while a window is open, the window is discarded with no pulse.
- R7: While `lockout` is high, no `wr_valid` is produced, and a window open at that moment is discarded.
- R8: `cmd_reset` rises one cycle after `lockout` rises and falls one cycle after `lockout` falls.
- R9: No write is accepted while `power_up_done` is low. After it rises, writes stay blocked until `we_n` and `ce_n` have each been seen high.
- R10: After a window is discarded, a new write needs the enables to reopen. Enables that simply stay low produce nothing.
- R11: `wr_valid` is high for exactly one cycle, GLITCH_CYCLES+2 clock cycles after the closing enable edge reaches the input pin. `wr_addr` and `wr_data` hold their values until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr_in | input | AW (20) | Bus address |
| data_in | input | DW (16) | Bus data |
| lockout | input | 1 | Low-supply lockout, high blocks writes |
| power_up_done | input | 1 | High once the power-up sequence is complete |
| wr_valid | output | 1 | One-cycle pulse for a qualified write |
| wr_addr | output | AW (20) | Address of the last qualified write |
| wr_data | output | DW (16) | Data of the last qualified write |
| cmd_reset | output | 1 | Reset request to the command logic |

## Verification
The bench builds the block with GLITCH_CYCLES set to 3 and keeps the default 20-bit address and 16-bit data widths. With a short filter, a 2-cycle pulse (rejected) and a 3-cycle pulse (accepted) fit in small windows, so both sides of the glitch threshold are tested. The short latency also allows enable falls and rises to be spaced further apart than the filter delay. The address bus carries junk until the later fall, and the data bus goes bad soon after the earlier rise, so a capture on the wrong edge produces a wrong value.

// File: rtl/wcq_pkg.sv
package wcq_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OPEN = 1'b1
    } wcq_state_t;

    localparam int STB_CE  = 0;
    localparam int STB_WE  = 1;
    localparam int STB_OE  = 2;
    localparam int STB_NUM = 3;
endpackage

// File: rtl/wcq_strobe_filter.sv
module wcq_strobe_filter #(
    parameter int GLITCH_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_raw,
    output logic strobe_filt
);
    localparam int CW = (GLITCH_CYCLES > 1) ? $clog2(GLITCH_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(GLITCH_CYCLES - 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          filt;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d    = flt_q;
        flt_d.s1 = strobe_raw;
        flt_d.s2 = flt_q.s1;
        if (flt_q.s2 == flt_q.filt) begin
            flt_d.cnt = '0;
        end else if (flt_q.cnt == LAST) begin
            flt_d.filt = flt_q.s2;
            flt_d.cnt  = '0;
        end else begin
            flt_d.cnt = flt_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q <= '{s1: 1'b1, s2: 1'b1, filt: 1'b1, cnt: '0};
        end else begin
            flt_q <= flt_d;
        end
    end

    assign strobe_filt = flt_q.filt;

    // The filtered level only ever moves to the value the synchroniser held
    p_filt_follows_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_q.filt != $past(flt_q.filt)) |-> (flt_q.filt == $past(flt_q.s2)));

    // A flip requires at least one earlier cycle of disagreement
    p_filt_needs_mismatch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_q.filt != $past(flt_q.filt)) |-> ($past(flt_q.s2) != $past(flt_q.filt)));
endmodule

// File: rtl/wcq_write_fsm.sv
module wcq_write_fsm
    import wcq_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_f,
    input  logic          we_f,
    input  logic          oe_f,
    input  logic          lockout,
    input  logic          power_up_done,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          cmd_reset
);
    typedef struct packed {
        wcq_state_t    state;
        logic          open_prev;
        logic          we_seen;
        logic          ce_seen;
        logic [AW-1:0] alat;
        logic          valid;
        logic [AW-1:0] waddr;
        logic [DW-1:0] wdata;
        logic          creq;
    } fsm_t;

    fsm_t st_d, st_q;
    logic win_open;
    logic pu_ok;
    logic win_start;

    always_comb begin
        win_open  = !ce_f && !we_f && oe_f;
        pu_ok     = st_q.we_seen && st_q.ce_seen && power_up_done;
        win_start = win_open && !st_q.open_prev && pu_ok && !lockout;

        st_d           = st_q;
        st_d.open_prev = win_open;
        st_d.valid     = 1'b0;
        st_d.creq      = lockout;

        if (!power_up_done) begin
            st_d.we_seen = 1'b0;
            st_d.ce_seen = 1'b0;
        end else begin
            st_d.we_seen = st_q.we_seen || we_f;
            st_d.ce_seen = st_q.ce_seen || ce_f;
        end

        unique case (st_q.state)
            ST_IDLE: begin
                if (win_start) begin
                    st_d.state = ST_OPEN;
                    st_d.alat  = addr_in;
                end
            end
            ST_OPEN: begin
                if (lockout || !power_up_done || !oe_f) begin
                    st_d.state = ST_IDLE;
                end else if (ce_f || we_f) begin
                    st_d.state = ST_IDLE;
                    st_d.valid = 1'b1;
                    st_d.waddr = st_q.alat;
                    st_d.wdata = data_in;
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, open_prev: 1'b0, we_seen: 1'b0,
                      ce_seen: 1'b0, alat: '0, valid: 1'b0, waddr: '0,
                      wdata: '0, creq: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_valid  = st_q.valid;
    assign wr_addr   = st_q.waddr;
    assign wr_data   = st_q.wdata;
    assign cmd_reset = st_q.creq;

    p_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    p_pulse_from_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(st_q.state == ST_OPEN));

    p_addr_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_OPEN && $past(st_q.state == ST_OPEN)) |-> $stable(st_q.alat));

    p_oe_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_OPEN && !oe_f) |=> !wr_valid);

    p_lockout_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |=> !wr_valid);

    p_reset_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lockout) |=> cmd_reset);

    p_powerup_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !power_up_done |=> (!wr_valid && st_q.state == ST_IDLE));

    p_outputs_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |-> ($stable(wr_addr) && $stable(wr_data)));
endmodule

// File: rtl/wr_cycle_qualifier.sv
module wr_cycle_qualifier
    import wcq_pkg::*;
#(
    parameter int AW            = 20,
    parameter int DW            = 16,
    parameter int GLITCH_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    input  logic          lockout,
    input  logic          power_up_done,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          cmd_reset
);
    logic [STB_NUM-1:0] stb_raw;
    logic [STB_NUM-1:0] stb_filt;

    always_comb begin
        stb_raw         = '1;
        stb_raw[STB_CE] = ce_n;
        stb_raw[STB_WE] = we_n;
        stb_raw[STB_OE] = oe_n;
    end

    for (genvar g = 0; g < STB_NUM; g++) begin : g_filt
        wcq_strobe_filter #(
            .GLITCH_CYCLES(GLITCH_CYCLES)
        ) i_filt (
            .clk        (clk),
            .rst_n      (rst_n),
            .strobe_raw (stb_raw[g]),
            .strobe_filt(stb_filt[g])
        );
    end

    wcq_write_fsm #(
        .AW(AW),
        .DW(DW)
    ) i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ce_f         (stb_filt[STB_CE]),
        .we_f         (stb_filt[STB_WE]),
        .oe_f         (stb_filt[STB_OE]),
        .lockout      (lockout),
        .power_up_done(power_up_done),
        .addr_in      (addr_in),
        .data_in      (data_in),
        .wr_valid     (wr_valid),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .cmd_reset    (cmd_reset)
    );
endmodule

// File: tb/test_wr_cycle_qualifier.sv
module test_wr_cycle_qualifier;
    localparam int PERIOD = 10;
    localparam int AW = 20;
    localparam int DW = 16;
    localparam int GC = 3;
    localparam int WIN = 50;
    localparam int NV = 11;

    typedef struct packed {
        logic [7:0]    ce_s;
        logic [7:0]    ce_e;
        logic [7:0]    we_s;
        logic [7:0]    we_e;
        logic [7:0]    oe_s;
        logic [7:0]    oe_e;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic [1:0]    n;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{8'd5,  8'd25, 8'd5,  8'd25, 8'd0,  8'd0,  20'h12345, 16'hBEEF, 2'd1},
        '{8'd5,  8'd30, 8'd15, 8'd30, 8'd0,  8'd0,  20'h0A5A5, 16'h1234, 2'd1},
        '{8'd15, 8'd30, 8'd5,  8'd30, 8'd0,  8'd0,  20'hF0F0F, 16'h5A5A, 2'd1},
        '{8'd5,  8'd35, 8'd5,  8'd20, 8'd0,  8'd0,  20'h33333, 16'hC3C3, 2'd1},
        '{8'd5,  8'd20, 8'd5,  8'd35, 8'd0,  8'd0,  20'h44444, 16'h0FF0, 2'd1},
        '{8'd5,  8'd30, 8'd10, 8'd12, 8'd0,  8'd0,  20'h55555, 16'h1111, 2'd0},
        '{8'd10, 8'd12, 8'd5,  8'd30, 8'd0,  8'd0,  20'h66666, 16'h2222, 2'd0},
        '{8'd5,  8'd30, 8'd10, 8'd13, 8'd0,  8'd0,  20'h77777, 16'h3333, 2'd1},
        '{8'd5,  8'd25, 8'd5,  8'd25, 8'd0,  8'd40, 20'h88888, 16'h4444, 2'd0},
        '{8'd5,  8'd25, 8'd5,  8'd25, 8'd12, 8'd30, 20'h99999, 16'h5555, 2'd0},
        '{8'd5,  8'd25, 8'd5,  8'd25, 8'd12, 8'd14, 20'hABCDE, 16'h6666, 2'd1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          we_n = 1'b1;
    logic          oe_n = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic [DW-1:0] data_in = '0;
    logic          lockout = 1'b0;
    logic          power_up_done = 1'b1;
    logic          wr_valid;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic          cmd_reset;

    int n_checks = 0;
    int n_fail = 0;
    int n_pulse;
    int p_time;
    int cr_seen;
    logic [AW-1:0] p_addr;
    logic [DW-1:0] p_data;

    always #(PERIOD/2) clk = ~clk;

    wr_cycle_qualifier #(
        .AW(AW), .DW(DW), .GLITCH_CYCLES(GC)
    ) i_wr_cycle_qualifier (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr_in(addr_in), .data_in(data_in), .lockout(lockout),
        .power_up_done(power_up_done), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .cmd_reset(cmd_reset)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic string vtag(input int i);
        case (i)
            0:       return "R3 both enables together";
            1, 2:    return "R4 later fall gives address";
            3, 4:    return "R5 earlier rise gives data";
            5, 6:    return "R2 short pulse rejected";
            7:       return "R2 threshold pulse accepted";
            8, 9:    return "R6 output enable inhibits";
            default: return "R6 output enable glitch ignored";
        endcase
    endfunction

    // Drive one window; inputs change after a falling edge, results are
    // sampled 1 time unit after each rising edge.
    task automatic run_window(input int ce_s, input int ce_e, input int we_s, input int we_e,
                              input int oe_s, input int oe_e, input int lk_s, input int lk_e,
                              input int pu_s, input logic [AW-1:0] a, input logic [DW-1:0] d);
        int lf;
        int er;
        lf = (ce_s > we_s) ? ce_s : we_s;
        er = (ce_e < we_e) ? ce_e : we_e;
        n_pulse = 0;
        p_time = -1;
        cr_seen = 0;
        for (int t = 0; t < WIN; t++) begin
            @(negedge clk);
            ce_n = !(t >= ce_s && t < ce_e);
            we_n = !(t >= we_s && t < we_e);
            oe_n = !(t >= oe_s && t < oe_e);
            lockout = (t >= lk_s && t < lk_e);
            power_up_done = (t >= pu_s);
            addr_in = (t >= lf) ? a : ~a;
            data_in = (t < er + GC + 4) ? d : ~d;
            @(posedge clk);
            #1;
            if (cmd_reset) cr_seen++;
            if (wr_valid) begin
                n_pulse++;
                p_time = t;
                p_addr = wr_addr;
                p_data = wr_data;
            end
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(wr_valid == 1'b0, "R1 wr_valid in reset", wr_valid, 0);
        check(cmd_reset == 1'b0, "R1 cmd_reset in reset", cmd_reset, 0);
        check(wr_addr == '0 && wr_data == '0, "R1 address and data in reset",
              {wr_addr, wr_data}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(wr_valid == 1'b0 && wr_addr == '0, "R1 after reset release", wr_valid, 0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            run_window(VECS[i].ce_s, VECS[i].ce_e, VECS[i].we_s, VECS[i].we_e,
                       VECS[i].oe_s, VECS[i].oe_e, 999, 999, 0, VECS[i].a, VECS[i].d);
            check(n_pulse == int'(VECS[i].n), {vtag(i), " pulse count"}, n_pulse, VECS[i].n);
            if (VECS[i].n == 2'd1) begin
                check(p_addr == VECS[i].a, {vtag(i), " address R4"}, p_addr, VECS[i].a);
                check(p_data == VECS[i].d, {vtag(i), " data R5"}, p_data, VECS[i].d);
                check(wr_addr == VECS[i].a && wr_data == VECS[i].d,
                      "R11 outputs held after pulse", {wr_addr, wr_data}, {VECS[i].a, VECS[i].d});
            end
            if (i == 0) begin
                check(p_time == 25 + GC + 2, "R11 pulse latency", p_time, 25 + GC + 2);
            end
        end

        // R7 / R8: lockout across a whole window
        run_window(5, 25, 5, 25, 0, 0, 0, 45, 0, 20'h13579, 16'h2468);
        check(n_pulse == 0, "R7 no write under lockout", n_pulse, 0);
        check(cr_seen == 45, "R8 cmd_reset follows lockout", cr_seen, 45);
        check(cmd_reset == 1'b0, "R8 cmd_reset released", cmd_reset, 0);

        // R7 / R10: lockout pulse inside an open window, enables stay low
        run_window(5, 25, 5, 25, 0, 0, 15, 18, 0, 20'h24680, 16'h9999);
        check(n_pulse == 0, "R10 aborted window not reopened", n_pulse, 0);

        // Normal write still works afterwards
        run_window(5, 25, 5, 25, 0, 0, 999, 999, 0, 20'h0BEEF, 16'hFACE);
        check(n_pulse == 1 && p_addr == 20'h0BEEF, "R7 write after lockout", p_addr, 20'h0BEEF);

        // R9: write while power-up not done
        run_window(5, 25, 5, 25, 0, 0, 999, 999, 60, 20'h11111, 16'h7777);
        check(n_pulse == 0, "R9 write before power-up done", n_pulse, 0);

        // R9: both enables low when power-up completes
        run_window(0, 30, 0, 20, 0, 0, 999, 999, 10, 20'h22222, 16'h8888);
        check(n_pulse == 0, "R9 enables low at power-up", n_pulse, 0);

        // R9: after both enables released, writes accepted
        run_window(5, 25, 5, 25, 0, 0, 999, 999, 0, 20'h3C3C3, 16'hA5A5);
        check(n_pulse == 1 && p_data == 16'hA5A5, "R9 write after release", p_data, 16'hA5A5);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule